// File: doc/BRIEF.md
# Retirement Control-Transfer Type Classifier

This block sits at the retirement stage of a processor core and assigns a trace type code to every retirement slot. It is given the decoded kind of the retiring instruction (branch, direct jump, register-indirect jump, upper-immediate load, PC-relative upper load, trap return or anything else), its destination and source register numbers, a compressed-encoding flag, the branch outcome, and the exception and interrupt flags of the slot. From these it produces a type code for a downstream trace encoder.

Direct and register-indirect jumps are split by the link-register calling convention on x1 and x5 into calls, plain jumps, returns, co-routine swaps and other jumps. Each of these is then marked as inferable, when the target is an immediate held in the jump itself, or as uninferable. A second output flags an uninferable jump whose source register was written by the upper-immediate or PC-relative load retired just before it, so the trace encoder can treat its target as known.

The parameter `ITYPE_W` selects the full 4-bit code set or a reduced 3-bit set. Both outputs are registered and follow the retirement inputs by one clock.

Top module: `itype_classifier`

## Requirements
- R1: While `rst` is high, and on the first clock after it is released, `itype_o` is 0 and `sijump_o` is 0.
- R2: Both outputs are registered. The code for the inputs sampled at a rising edge appears right after that edge and holds for one cycle.
- R3: `exc_i` gives code 1 and `irq_i` gives code 2. The exception wins when both are set. Either one overrides any classification of the instruction in the slot and applies even when `ret_valid_i` is low.
- R4: If no trap is flagged, a slot with `ret_valid_i` low gives 0. Otherwise the `kind_i` encoding is 0 other, 1 conditional branch, 2 direct jump, 3 register-indirect jump, 4 upper-immediate load, 5 PC-relative upper load, 6 trap return, 7 reserved. A branch gives 5 when `taken_i` is set and 4 when it is not. A trap return gives 3. Kinds 0, 4, 5 and 7 give 0.
- R5: Full width, direct jump: a link in x1 or x5 is an inferable call (9), a link in x0 is an inferable jump (11), and any other destination is an inferable other jump (15).
- R6: Full width, indirect jump. Destination x1 or x5 with the other link register as source is a swap (12). Any other indirect jump with destination x1 or x5 is an uninferable call (8). Destination outside {x1,x5} with source x1 or x5 is a return (13). Destination x0 with any other source is an uninferable jump (10). All remaining cases are uninferable other (14).
- R7: For a compressed jump, a nonzero `rd_i` is treated as x1 and zero as x0, whatever its value.
- R8: With `ITYPE_W`=3, every indirect jump reports 6, every direct jump reports 0, and codes 7 and above never appear.
- R9: `sijump_o` is 1 for an indirect jump whose source equals the nonzero destination of the instruction retired directly before it, when that instruction was an upper-immediate or PC-relative upper load. Cycles with nothing retired in between do not break the pairing.
- R10: Any other retired instruction or any trap between the load and the jump cancels the pairing. At full width `sijump_o` is 0 for returns (13). It is 0 whenever the code is not an uninferable jump code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ret_valid_i | input | 1 | An instruction retires in this slot |
| kind_i | input | 3 | Decoded instruction kind (encoding in R4) |
| rd_i | input | REG_W | Destination register number |
| rs1_i | input | REG_W | Source register number |
| compressed_i | input | 1 | Instruction uses the compressed encoding |
| taken_i | input | 1 | Branch outcome |
| exc_i | input | 1 | Exception traps after this slot |
| irq_i | input | 1 | Interrupt traps after this slot |
| itype_o | output | ITYPE_W | Registered type code |
| sijump_o | output | 1 | Registered sequentially-inferable flag |

## Verification
The bench builds two instances side by side from the same stimulus: one with `ITYPE_W`=4 and one with `ITYPE_W`=3, both with `REG_W`=5. The full-width instance exposes every link-register split of the calling-convention table, including the return exclusion for the sequential flag. The narrow instance shows that all of these collapse to code 6 or 0 while the sequential flag still follows the load-then-jump pairing. Register numbers are biased toward x0, x1 and x5, and jump sources are often steered onto the previous destination, so that swaps, returns and load-to-jump pairs occur often under random traffic.

// File: rtl/itc_pkg.sv
package itc_pkg;

  typedef enum logic [2:0] {
    K_OTHER  = 3'd0,
    K_BRANCH = 3'd1,
    K_JAL    = 3'd2,
    K_JALR   = 3'd3,
    K_LUI    = 3'd4,
    K_AUIPC  = 3'd5,
    K_XRET   = 3'd6,
    K_RSVD   = 3'd7
  } instr_kind_e;

  typedef enum logic [2:0] {
    CAT_NONE  = 3'd0,
    CAT_CALL  = 3'd1,
    CAT_JUMP  = 3'd2,
    CAT_RET   = 3'd3,
    CAT_SWAP  = 3'd4,
    CAT_OTHER = 3'd5
  } jump_cat_e;

  localparam logic [3:0] IT_NONE      = 4'd0;
  localparam logic [3:0] IT_EXC       = 4'd1;
  localparam logic [3:0] IT_IRQ       = 4'd2;
  localparam logic [3:0] IT_XRET      = 4'd3;
  localparam logic [3:0] IT_BR_NT     = 4'd4;
  localparam logic [3:0] IT_BR_T      = 4'd5;
  localparam logic [3:0] IT_UNINF_ANY = 4'd6;
  localparam logic [3:0] IT_CALL_U    = 4'd8;
  localparam logic [3:0] IT_CALL_I    = 4'd9;
  localparam logic [3:0] IT_JUMP_U    = 4'd10;
  localparam logic [3:0] IT_JUMP_I    = 4'd11;
  localparam logic [3:0] IT_SWAP      = 4'd12;
  localparam logic [3:0] IT_RET       = 4'd13;
  localparam logic [3:0] IT_OTHER_U   = 4'd14;
  localparam logic [3:0] IT_OTHER_I   = 4'd15;

  localparam int LINK_A = 1;
  localparam int LINK_B = 5;

endpackage

// File: rtl/itc_jump_class.sv
module itc_jump_class
  import itc_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic             is_jal,
  input  logic             is_jalr,
  input  logic [REG_W-1:0] rd,
  input  logic [REG_W-1:0] rs1,
  input  logic             compressed,
  output jump_cat_e        cat
);
  localparam logic [REG_W-1:0] RA = REG_W'(LINK_A);
  localparam logic [REG_W-1:0] RB = REG_W'(LINK_B);

  logic [REG_W-1:0] rd_eff;
  logic rd_link, rs_link, rd_zero;

  // compressed jumps can only link to the first link register or to x0
  assign rd_eff  = compressed ? ((rd != '0) ? RA : '0) : rd;
  assign rd_link = (rd_eff == RA) || (rd_eff == RB);
  assign rs_link = (rs1 == RA) || (rs1 == RB);
  assign rd_zero = (rd_eff == '0);

  always_comb begin
    cat = CAT_NONE;
    if (is_jal) begin
      if (rd_link)      cat = CAT_CALL;
      else if (rd_zero) cat = CAT_JUMP;
      else              cat = CAT_OTHER;
    end else if (is_jalr) begin
      if (rd_link) begin
        if (rs_link && (rs1 != rd_eff)) cat = CAT_SWAP;
        else                            cat = CAT_CALL;
      end else if (rs_link) begin
        cat = CAT_RET;
      end else if (rd_zero) begin
        cat = CAT_JUMP;
      end else begin
        cat = CAT_OTHER;
      end
    end
  end
endmodule

// File: rtl/itc_seq_track.sv
module itc_seq_track
  import itc_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ret_valid,
  input  logic             trap,
  input  instr_kind_e      kind,
  input  logic [REG_W-1:0] rd,
  input  logic [REG_W-1:0] rs1,
  output logic             pair_hit
);
  logic             prev_load_q;
  logic [REG_W-1:0] prev_rd_q;

  // remembers whether the most recent retirement wrote an upper constant
  always_ff @(posedge clk) begin
    if (rst) begin
      prev_load_q <= 1'b0;
      prev_rd_q   <= '0;
    end else if (trap) begin
      prev_load_q <= 1'b0;
    end else if (ret_valid) begin
      prev_load_q <= (kind == K_LUI) || (kind == K_AUIPC);
      prev_rd_q   <= rd;
    end
  end

  assign pair_hit = ret_valid && !trap && (kind == K_JALR) &&
                    prev_load_q && (prev_rd_q != '0) && (prev_rd_q == rs1);
endmodule

// File: rtl/itc_code_sel.sv
module itc_code_sel
  import itc_pkg::*;
#(
  parameter int ITYPE_W = 4
) (
  input  logic               ret_valid,
  input  instr_kind_e        kind,
  input  logic               taken,
  input  logic               exc,
  input  logic               irq,
  input  jump_cat_e          cat,
  output logic [ITYPE_W-1:0] code
);
  logic [3:0] jcode;
  logic       uninf;

  assign uninf = (kind == K_JALR);

  generate
    if (ITYPE_W == 3) begin : g_narrow
      always_comb jcode = uninf ? IT_UNINF_ANY : IT_NONE;
    end else begin : g_full
      always_comb begin
        unique case (cat)
          CAT_CALL:  jcode = uninf ? IT_CALL_U  : IT_CALL_I;
          CAT_JUMP:  jcode = uninf ? IT_JUMP_U  : IT_JUMP_I;
          CAT_OTHER: jcode = uninf ? IT_OTHER_U : IT_OTHER_I;
          CAT_SWAP:  jcode = IT_SWAP;
          CAT_RET:   jcode = IT_RET;
          default:   jcode = IT_NONE;
        endcase
      end
    end
  endgenerate

  logic [3:0] full;
  always_comb begin
    full = IT_NONE;
    if (exc)             full = IT_EXC;
    else if (irq)        full = IT_IRQ;
    else if (ret_valid) begin
      unique case (kind)
        K_BRANCH:       full = taken ? IT_BR_T : IT_BR_NT;
        K_XRET:         full = IT_XRET;
        K_JAL, K_JALR:  full = jcode;
        default:        full = IT_NONE;
      endcase
    end
  end

  assign code = full[ITYPE_W-1:0];
endmodule

// File: rtl/itype_classifier.sv
module itype_classifier
  import itc_pkg::*;
#(
  parameter int ITYPE_W   = 4,
  parameter int REG_W     = 5,
  parameter bit SIJUMP_EN = 1'b1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               ret_valid_i,
  input  logic [2:0]         kind_i,
  input  logic [REG_W-1:0]   rd_i,
  input  logic [REG_W-1:0]   rs1_i,
  input  logic               compressed_i,
  input  logic               taken_i,
  input  logic               exc_i,
  input  logic               irq_i,
  output logic [ITYPE_W-1:0] itype_o,
  output logic               sijump_o
);
  localparam bit FULL = (ITYPE_W >= 4);

  instr_kind_e        kind;
  jump_cat_e          cat;
  logic               trap;
  logic               pair_hit;
  logic               sij_d;
  logic [ITYPE_W-1:0] code_d;

  assign kind = instr_kind_e'(kind_i);
  assign trap = exc_i || irq_i;

  itc_jump_class #(.REG_W(REG_W)) u_class (
    .is_jal     (kind == K_JAL),
    .is_jalr    (kind == K_JALR),
    .rd         (rd_i),
    .rs1        (rs1_i),
    .compressed (compressed_i),
    .cat        (cat)
  );

  itc_seq_track #(.REG_W(REG_W)) u_track (
    .clk       (clk),
    .rst       (rst),
    .ret_valid (ret_valid_i),
    .trap      (trap),
    .kind      (kind),
    .rd        (rd_i),
    .rs1       (rs1_i),
    .pair_hit  (pair_hit)
  );

  itc_code_sel #(.ITYPE_W(ITYPE_W)) u_sel (
    .ret_valid (ret_valid_i),
    .kind      (kind),
    .taken     (taken_i),
    .exc       (exc_i),
    .irq       (irq_i),
    .cat       (cat),
    .code      (code_d)
  );

  // returns carry no sequential flag in the full code set
  assign sij_d = SIJUMP_EN && pair_hit && !(FULL && (cat == CAT_RET));

  always_ff @(posedge clk) begin
    if (rst) begin
      itype_o  <= '0;
      sijump_o <= 1'b0;
    end else begin
      itype_o  <= code_d;
      sijump_o <= sij_d;
    end
  end
endmodule

// File: rtl/itc_checker.sv
module itc_checker #(
  parameter int ITYPE_W = 4,
  parameter int REG_W   = 5
) (
  input logic               clk,
  input logic               rst,
  input logic               ret_valid_i,
  input logic [2:0]         kind_i,
  input logic [REG_W-1:0]   rd_i,
  input logic [REG_W-1:0]   rs1_i,
  input logic               compressed_i,
  input logic               taken_i,
  input logic               exc_i,
  input logic               irq_i,
  input logic [ITYPE_W-1:0] itype_o,
  input logic               sijump_o
);
  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (itype_o == '0 && !sijump_o));

  a_r3_exc_first: assert property (@(posedge clk) disable iff (rst)
    exc_i |=> (int'(itype_o) == 1));

  a_r3_irq_code: assert property (@(posedge clk) disable iff (rst)
    (irq_i && !exc_i) |=> (int'(itype_o) == 2));

  a_r4_idle_zero: assert property (@(posedge clk) disable iff (rst)
    (!ret_valid_i && !exc_i && !irq_i) |=> (itype_o == '0 && !sijump_o));

  a_r2_taken_branch: assert property (@(posedge clk) disable iff (rst)
    (ret_valid_i && !exc_i && !irq_i && kind_i == 3'd1 && taken_i)
      |=> (int'(itype_o) == 5));

  a_r8_narrow_range: assert property (@(posedge clk) disable iff (rst)
    (ITYPE_W != 3) || (int'(itype_o) != 7));

  a_r10_sij_code: assert property (@(posedge clk) disable iff (rst)
    sijump_o |-> ((ITYPE_W == 3) ? (int'(itype_o) == 6)
                 : (int'(itype_o) == 8 || int'(itype_o) == 10 ||
                    int'(itype_o) == 12 || int'(itype_o) == 14)));
endmodule

bind itype_classifier itc_checker #(.ITYPE_W(ITYPE_W), .REG_W(REG_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .ret_valid_i  (ret_valid_i),
  .kind_i       (kind_i),
  .rd_i         (rd_i),
  .rs1_i        (rs1_i),
  .compressed_i (compressed_i),
  .taken_i      (taken_i),
  .exc_i        (exc_i),
  .irq_i        (irq_i),
  .itype_o      (itype_o),
  .sijump_o     (sijump_o)
);

// File: tb/sim_itype_classifier.sv
`timescale 1ns/1ps
module sim_itype_classifier;
  localparam int RW = 5;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          v = 1'b0;
  logic [2:0]    kind = '0;
  logic [RW-1:0] rd = '0, rs = '0;
  logic          cmp = 1'b0, tk = 1'b0, exc = 1'b0, irq = 1'b0;
  logic [3:0]    it4;
  logic [2:0]    it3;
  logic          sj4, sj3;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  itype_classifier #(.ITYPE_W(4), .REG_W(RW)) u0 (
    .clk(clk), .rst(rst), .ret_valid_i(v), .kind_i(kind), .rd_i(rd), .rs1_i(rs),
    .compressed_i(cmp), .taken_i(tk), .exc_i(exc), .irq_i(irq),
    .itype_o(it4), .sijump_o(sj4));

  itype_classifier #(.ITYPE_W(3), .REG_W(RW)) u1 (
    .clk(clk), .rst(rst), .ret_valid_i(v), .kind_i(kind), .rd_i(rd), .rs1_i(rs),
    .compressed_i(cmp), .taken_i(tk), .exc_i(exc), .irq_i(irq),
    .itype_o(it3), .sijump_o(sj3));

  // reference model state
  bit m_prev = 1'b0;
  int m_prev_rd = 0;
  int e4, e3, s4, s3;

  function automatic bit lk(int r);
    return (r == 1) || (r == 5);
  endfunction

  // 0 none, 1 call, 2 jump, 3 return, 4 swap, 5 other
  function automatic int cat_of(int k, int d, int s, bit c);
    int de;
    de = c ? ((d != 0) ? 1 : 0) : d;
    if (k == 2) return lk(de) ? 1 : ((de == 0) ? 2 : 5);
    if (k == 3) begin
      if (lk(de)) return (lk(s) && s != de) ? 4 : 1;
      if (lk(s)) return 3;
      return (de == 0) ? 2 : 5;
    end
    return 0;
  endfunction

  function automatic int exp_code(int w, bit vv, int k, int d, int s, bit c,
                                  bit t, bit e, bit i);
    int ct, base;
    if (e) return 1;
    if (i) return 2;
    if (!vv) return 0;
    if (k == 1) return t ? 5 : 4;
    if (k == 6) return 3;
    if (k != 2 && k != 3) return 0;
    if (w == 3) return (k == 3) ? 6 : 0;
    ct = cat_of(k, d, s, c);
    case (ct)
      1: base = 8;
      2: base = 10;
      3: base = 13;
      4: base = 12;
      default: base = 14;
    endcase
    return (k == 3) ? base : base + 1;
  endfunction

  function automatic int exp_sij(int w, bit vv, int k, int d, int s, bit c,
                                 bit e, bit i, bit pv, int prd);
    if (!(vv && !e && !i && k == 3)) return 0;
    if (w == 4 && exp_code(4, vv, k, d, s, c, 1'b0, e, i) == 13) return 0;
    return (pv && prd != 0 && prd == s) ? 1 : 0;
  endfunction

  task automatic chk(int act, int exp, string tag);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // apply one slot at a negedge, compare at the next negedge
  task automatic step(bit vv, int k, int d, int s, bit c, bit t, bit e, bit i,
                      int lit4, int lits, string tag);
    v = vv; kind = 3'(k); rd = RW'(d); rs = RW'(s); cmp = c; tk = t; exc = e; irq = i;
    e4 = exp_code(4, vv, k, d, s, c, t, e, i);
    e3 = exp_code(3, vv, k, d, s, c, t, e, i);
    s4 = exp_sij(4, vv, k, d, s, c, e, i, m_prev, m_prev_rd);
    s3 = exp_sij(3, vv, k, d, s, c, e, i, m_prev, m_prev_rd);
    if (e || i) m_prev = 1'b0;
    else if (vv) begin
      m_prev = (k == 4 || k == 5);
      m_prev_rd = d;
    end
    @(posedge clk);
    @(negedge clk);
    if (lit4 >= 0) chk(int'(it4), lit4, {tag, " code"});
    else           chk(int'(it4), e4, {tag, " code"});
    if (lits >= 0) chk(int'(sj4), lits, {tag, " flag"});
    else           chk(int'(sj4), s4, {tag, " flag"});
    chk(int'(it3), e3, {tag, " narrow code"});
    chk(int'(sj3), s3, {tag, " narrow flag"});
  endtask

  function automatic int pick_reg();
    int r;
    r = $urandom % 6;
    if (r == 0) return 0;
    if (r == 1) return 1;
    if (r == 2) return 5;
    return $urandom % 32;
  endfunction

  initial begin : watchdog
    #(20 * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin : main
    int last_rd;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    chk(int'(it4), 0, "R1 reset code");
    chk(int'(sj4), 0, "R1 reset flag");
    rst = 1'b0;
    v = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk(int'(it4), 0, "R1 after release");

    // R5 direct jumps
    step(1, 2, 0, 0, 0, 0, 0, 0, 11, 0, "R5 jal x0");
    step(1, 2, 1, 0, 0, 0, 0, 0, 9, 0, "R5 jal x1");
    step(1, 2, 5, 0, 0, 0, 0, 0, 9, 0, "R5 jal x5");
    step(1, 2, 7, 0, 0, 0, 0, 0, 15, 0, "R5 jal x7");
    // R6 indirect jumps
    step(1, 3, 1, 5, 0, 0, 0, 0, 12, 0, "R6 jalr x1,x5");
    step(1, 3, 5, 1, 0, 0, 0, 0, 12, 0, "R6 jalr x5,x1");
    step(1, 3, 1, 3, 0, 0, 0, 0, 8, 0, "R6 jalr x1,x3");
    step(1, 3, 1, 1, 0, 0, 0, 0, 8, 0, "R6 jalr x1,x1");
    step(1, 3, 0, 1, 0, 0, 0, 0, 13, 0, "R6 jalr x0,x1");
    step(1, 3, 9, 5, 0, 0, 0, 0, 13, 0, "R6 jalr x9,x5");
    step(1, 3, 0, 7, 0, 0, 0, 0, 10, 0, "R6 jalr x0,x7");
    step(1, 3, 9, 7, 0, 0, 0, 0, 14, 0, "R6 jalr x9,x7");
    // R7 compressed forms
    step(1, 3, 3, 5, 1, 0, 0, 0, 12, 0, "R7 c.jalr x5");
    step(1, 2, 9, 0, 1, 0, 0, 0, 9, 0, "R7 c.jal");
    step(1, 2, 0, 0, 1, 0, 0, 0, 11, 0, "R7 c.j");
    step(1, 3, 0, 5, 1, 0, 0, 0, 13, 0, "R7 c.jr x5");
    // R4 other kinds
    step(1, 1, 0, 0, 0, 1, 0, 0, 5, 0, "R4 taken");
    step(1, 1, 0, 0, 0, 0, 0, 0, 4, 0, "R4 not taken");
    step(1, 6, 0, 0, 0, 0, 0, 0, 3, 0, "R4 xret");
    step(1, 4, 3, 0, 0, 0, 0, 0, 0, 0, "R4 lui");
    step(1, 7, 3, 0, 0, 0, 0, 0, 0, 0, "R4 reserved");
    step(0, 3, 0, 1, 0, 0, 0, 0, 0, 0, "R4 idle");
    // R3 traps
    step(1, 3, 1, 5, 0, 0, 1, 0, 1, 0, "R3 exc over jump");
    step(1, 1, 0, 0, 0, 1, 0, 1, 2, 0, "R3 irq over branch");
    step(1, 3, 0, 0, 0, 0, 1, 1, 1, 0, "R3 exc over irq");
    step(0, 0, 0, 0, 0, 0, 0, 1, 2, 0, "R3 irq no retire");
    // R9 pairing
    step(1, 4, 6, 0, 0, 0, 0, 0, 0, 0, "R9 lui x6");
    step(1, 3, 0, 6, 0, 0, 0, 0, 10, 1, "R9 jalr x0,x6");
    step(1, 4, 6, 0, 0, 0, 0, 0, 0, 0, "R9 lui x6 b");
    step(1, 3, 0, 7, 0, 0, 0, 0, 10, 0, "R9 reg mismatch");
    step(1, 5, 6, 0, 0, 0, 0, 0, 0, 0, "R9 auipc x6");
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R9 gap");
    step(1, 3, 1, 6, 0, 0, 0, 0, 8, 1, "R9 call after gap");
    step(1, 4, 0, 0, 0, 0, 0, 0, 0, 0, "R9 lui x0");
    step(1, 3, 0, 0, 0, 0, 0, 0, 10, 0, "R9 x0 never pairs");
    // R10 cancellation
    step(1, 4, 6, 0, 0, 0, 0, 0, 0, 0, "R10 lui x6");
    step(1, 1, 0, 0, 0, 0, 0, 0, 4, 0, "R10 branch between");
    step(1, 3, 0, 6, 0, 0, 0, 0, 10, 0, "R10 broken by branch");
    step(1, 4, 6, 0, 0, 0, 0, 0, 0, 0, "R10 lui x6 c");
    step(0, 0, 0, 0, 0, 0, 1, 0, 1, 0, "R10 exc between");
    step(1, 3, 0, 6, 0, 0, 0, 0, 10, 0, "R10 broken by trap");
    step(1, 4, 1, 0, 0, 0, 0, 0, 0, 0, "R10 lui x1");
    step(1, 3, 0, 1, 0, 0, 0, 0, 13, 0, "R10 return no flag");
    step(1, 4, 6, 0, 0, 0, 0, 0, 0, 0, "R10 lui x6 d");
    step(1, 2, 0, 6, 0, 0, 0, 0, 11, 0, "R10 direct no flag");

    // R8 and all others: random traffic against the model
    last_rd = 0;
    for (int n = 0; n < 3000; n++) begin
      int k, d, s;
      bit vv, e, i;
      k = $urandom % 8;
      if ($urandom % 3 == 0) k = ($urandom % 2) ? 4 : 3;
      d = pick_reg();
      s = pick_reg();
      if (k == 3 && $urandom % 2) s = last_rd;
      vv = ($urandom % 8) != 0;
      e = ($urandom % 16) == 0;
      i = ($urandom % 16) == 0;
      if (vv) last_rd = d;
      step(vv, k, d, s, bit'($urandom % 2), bit'($urandom % 2), e, i,
           -1, -1, "R8 R6 random");
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule